// File: doc/BRIEF.md
# Chunked I2C Master Engine

This block is an I2C bus master that moves data in chunks of up to 32 bytes. Software places outgoing bytes in a transmit window of eight 32-bit words and collects incoming bytes from a receive window of the same size. It issues START and STOP as separate commands. Each chunk is launched by writing a byte count.

Three chunk modes are supported. Transmit sends bytes straight from the transmit window. Combined mode sends a write address and a register address of up to three bytes, then a repeated START and the read address, and then receives. Plain receive continues a read with no address phase. A keep-ACK control lets a read run on past the end of a chunk.

Bus timing comes from an external `tick` pulse. Every bit takes four tick phases. SCL and SDA are open-drain, so each pin is modelled as a pull-low enable plus, for SDA, an input.

Top module: `i2c_chunk_master`

## Requirements
- R1: After reset, both pull-low enables are 0, and the pending register (word 5) reads 0.
- R2: Control word 0 has these fields: bit 0 enable, bits [2:1] mode (00 transmit, 01 combined, 10 plain receive), bit 3 START, bit 4 STOP and bit 5 keep-ACK. Writing enable with START while the engine is idle produces a START. SCL is then held low and pending bit 0 is set. Writing enable with STOP produces a STOP. Both lines are then released and pending bit 1 is set.
- R3: The pending bits are 0 START done, 1 STOP done, 2 transmit chunk done, 3 receive chunk done and 4 NAK. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R4: In transmit mode, writing a count N to word 3 sends N bytes from words 8..15. The bytes go in word order and, within a word, byte k is taken from bits [8k+7:8k]. Each byte is sent MSB first. Pending bit 2 is set when the chunk completes.
- R5: In combined mode, writing a count to word 4 starts the address phase. Word 1 holds a 7-bit target address. Word 2 holds the register address in bits [23:0], sent low byte first, and its length (0..3) in bits [25:24]. With a nonzero length, the engine sends {addr,0}, then the register bytes, then a repeated START, then {addr,1}. With length 0, it sends only {addr,1}.
- R6: Received bytes are stored into words 16..23 in arrival order, starting at byte 0 of word 16 for every chunk. The packing is little-endian, as in R4. Pending bit 3 is set when the chunk completes.
- R7: Every received byte is acknowledged except the last byte of a chunk. The last byte is NAKed unless keep-ACK is set.
- R8: Plain receive mode reads the counted bytes with no START and no address byte.
- R9: A NAK on any transmitted byte sets pending bit 4 and ends the chunk without setting pending bit 2.
- R10: Writing control with enable 0 aborts any activity. Both lines are released at the next clock edge, and no further bus activity follows.
- R11: The bus state moves only on cycles where `tick` is high. While SCL is released inside a byte, SDA does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Bus phase advance pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
A register write takes effect at the clock edge that captures it. The only register result checked one cycle later is the release of both lines after a disable. Bus results arrive a tick-dependent number of cycles later, at four ticks per bit. For those, the bench polls the pending word each cycle with a bounded wait and compares the bytes and ACK bits its own target model recorded only once the matching flag is up. The stall check freezes `tick` and compares the pin levels over forty cycles.

// File: rtl/i2c_chunk_master.sv
module i2c_chunk_master #(
  parameter int WORDS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  localparam int BYTES = WORDS * 4;
  localparam int IW = $clog2(BYTES);
  localparam int CW = IW + 1;
  localparam int WI = $clog2(WORDS);
  localparam logic [4:0] TXB = 5'd8;
  localparam logic [4:0] TXE = 5'(8 + WORDS);
  localparam logic [4:0] RXB = 5'd16;
  localparam logic [4:0] RXE = 5'(16 + WORDS);
  localparam logic [4:0] A_CTRL = 5'd0, A_ADDR = 5'd1, A_REG = 5'd2,
                         A_TXC = 5'd3, A_RXC = 5'd4, A_PEND = 5'd5;

  typedef enum logic [2:0] {S_IDLE, S_START, S_STOP, S_WB, S_RB} st_t;
  typedef enum logic [1:0] {H_DATA, H_WADDR, H_REG, H_RADDR} hdr_t;

  st_t st;
  hdr_t hdr;
  logic en, last_ack, hold, seq, nakd;
  logic [1:0] mode, rlen, ph;
  logic [6:0] addr7;
  logic [23:0] rega;
  logic [CW-1:0] txcnt, rxcnt;
  logic [4:0] pend;
  logic [3:0] bitc;
  logic [7:0] sh;
  logic [IW-1:0] idx;
  logic [31:0] tx_w [0:WORDS-1];
  logic [31:0] rx_w [0:WORDS-1];

  logic [7:0] txb;
  logic rlast;

  assign rlast = (CW'(idx) + 1'b1) == rxcnt;

  always_comb begin
    case (hdr)
      H_DATA:  txb = tx_w[idx[IW-1:2]][8*idx[1:0] +: 8];
      H_WADDR: txb = {addr7, 1'b0};
      H_REG:   txb = rega[8*idx[1:0] +: 8];
      default: txb = {addr7, 1'b1};
    endcase
  end

  always_comb begin
    scl_oe = hold;
    sda_oe = 1'b0;
    case (st)
      S_START: begin
        scl_oe = (ph == 2'd0) ? hold : (ph == 2'd3);
        sda_oe = ph[1];
      end
      S_STOP: begin
        scl_oe = (ph == 2'd0);
        sda_oe = !ph[1];
      end
      S_WB: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        sda_oe = (bitc < 4'd8) ? !txb[3'(4'd7 - bitc)] : 1'b0;
      end
      S_RB: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        sda_oe = (bitc == 4'd8) && !(rlast && !last_ack);
      end
      default: ;
    endcase
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr >= TXB && rd_addr < TXE)
      rd_data = tx_w[rd_addr[WI-1:0]];
    else if (rd_addr >= RXB && rd_addr < RXE)
      rd_data = rx_w[rd_addr[WI-1:0]];
    else
      case (rd_addr)
        A_CTRL:  rd_data = {26'd0, last_ack, 2'b00, mode, en};
        A_ADDR:  rd_data = {25'd0, addr7};
        A_REG:   rd_data = {6'd0, rlen, rega};
        A_TXC:   rd_data = 32'(txcnt);
        A_RXC:   rd_data = 32'(rxcnt);
        A_PEND:  rd_data = {27'd0, pend};
        default: rd_data = '0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      hdr <= H_DATA;
      en <= 1'b0;
      last_ack <= 1'b0;
      hold <= 1'b0;
      seq <= 1'b0;
      nakd <= 1'b0;
      mode <= '0;
      rlen <= '0;
      ph <= '0;
      addr7 <= '0;
      rega <= '0;
      txcnt <= '0;
      rxcnt <= '0;
      pend <= '0;
      bitc <= '0;
      sh <= '0;
      idx <= '0;
      for (int i = 0; i < WORDS; i++) begin
        tx_w[i] <= '0;
        rx_w[i] <= '0;
      end
    end else begin
      if (wr_en && wr_addr == A_PEND)
        pend <= pend & ~wr_data[4:0];

      if (tick) begin
        case (st)
          S_START:
            if (ph == 2'd3) begin
              ph <= '0;
              hold <= 1'b1;
              if (seq) begin
                st <= S_WB;
                hdr <= H_RADDR;
                bitc <= '0;
              end else begin
                st <= S_IDLE;
                pend[0] <= 1'b1;
              end
            end else ph <= ph + 2'd1;
          S_STOP:
            if (ph == 2'd3) begin
              ph <= '0;
              hold <= 1'b0;
              st <= S_IDLE;
              pend[1] <= 1'b1;
            end else ph <= ph + 2'd1;
          S_WB, S_RB: begin
            if (ph == 2'd1) begin
              if (st == S_WB) begin
                if (bitc == 4'd8) nakd <= sda_in;
              end else if (bitc != 4'd8) sh <= {sh[6:0], sda_in};
            end
            if (ph != 2'd3) ph <= ph + 2'd1;
            else begin
              ph <= '0;
              if (bitc != 4'd8) bitc <= bitc + 4'd1;
              else begin
                bitc <= '0;
                if (st == S_RB) begin
                  rx_w[idx[IW-1:2]][8*idx[1:0] +: 8] <= sh;
                  if (rlast) begin
                    st <= S_IDLE;
                    pend[3] <= 1'b1;
                  end else idx <= idx + 1'b1;
                end else if (nakd) begin
                  st <= S_IDLE;
                  pend[4] <= 1'b1;
                end else
                  case (hdr)
                    H_DATA:
                      if ((CW'(idx) + 1'b1) == txcnt) begin
                        st <= S_IDLE;
                        pend[2] <= 1'b1;
                      end else idx <= idx + 1'b1;
                    H_WADDR: begin
                      hdr <= H_REG;
                      idx <= '0;
                    end
                    H_REG:
                      if ((CW'(idx) + 1'b1) == CW'(rlen)) begin
                        st <= S_START;
                        seq <= 1'b1;
                      end else idx <= idx + 1'b1;
                    default: begin
                      idx <= '0;
                      if (rxcnt == '0) begin
                        st <= S_IDLE;
                        pend[3] <= 1'b1;
                      end else st <= S_RB;
                    end
                  endcase
              end
            end
          end
          default: ;
        endcase
      end

      if (wr_en) begin
        if (wr_addr >= TXB && wr_addr < TXE)
          tx_w[wr_addr[WI-1:0]] <= wr_data;
        case (wr_addr)
          A_CTRL: begin
            en <= wr_data[0];
            mode <= wr_data[2:1];
            last_ack <= wr_data[5];
            if (!wr_data[0]) begin
              st <= S_IDLE;
              hold <= 1'b0;
              ph <= '0;
              bitc <= '0;
            end else if (st == S_IDLE) begin
              if (wr_data[3]) begin
                st <= S_START;
                seq <= 1'b0;
                ph <= '0;
              end else if (wr_data[4]) begin
                st <= S_STOP;
                ph <= '0;
              end
            end
          end
          A_ADDR: addr7 <= wr_data[6:0];
          A_REG: begin
            rega <= wr_data[23:0];
            rlen <= wr_data[25:24];
          end
          A_TXC: begin
            txcnt <= wr_data[CW-1:0];
            if (en && st == S_IDLE && mode == 2'd0) begin
              if (wr_data[CW-1:0] == '0) pend[2] <= 1'b1;
              else begin
                st <= S_WB;
                hdr <= H_DATA;
                idx <= '0;
                bitc <= '0;
                ph <= '0;
              end
            end
          end
          A_RXC: begin
            rxcnt <= wr_data[CW-1:0];
            if (en && st == S_IDLE) begin
              if (mode == 2'd1) begin
                st <= S_WB;
                hdr <= (rlen != 2'd0) ? H_WADDR : H_RADDR;
                idx <= '0;
                bitc <= '0;
                ph <= '0;
              end else if (mode == 2'd2) begin
                if (wr_data[CW-1:0] == '0) pend[3] <= 1'b1;
                else begin
                  st <= S_RB;
                  idx <= '0;
                  bitc <= '0;
                  ph <= '0;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && !wr_data[0]) |=> (!scl_oe && !sda_oe));

  // R11
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(scl_oe) && $stable(sda_oe)));

  // R11
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_WB || st == S_RB) && $past(st) == st && !scl_oe && !$past(scl_oe))
      |-> $stable(sda_oe));

  // R9
  nak_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[4]) |-> ($past(tick) && $past(sda_in)));

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[1]) |-> (!scl_oe && !sda_oe));

  // R2
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> scl_oe);
endmodule

// File: tb/i2c_chunk_master_test.sv
module i2c_chunk_master_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, tick_en = 1'b1;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic scl_oe, sda_oe;
  logic t_low = 1'b0;
  logic scl, sda;
  assign scl = !scl_oe;
  assign sda = !sda_oe && !t_low;

  int nchk = 0, nfail = 0;

  i2c_chunk_master uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda)
  );

  always #2 clk = ~clk;

  always @(negedge clk) tick <= tick_en ? !tick : 1'b0;

  // behavioural target model
  logic ps = 1'b1, pd = 1'b1;
  int bitn = 0, nstarts = 0, nstops = 0, nak_at = -1;
  logic [7:0] sr = '0, cur = '0;
  bit sending = 0, first = 0, tgt_clr = 0;
  logic [7:0] bq[$];
  bit mack[$];
  logic [7:0] rdq[$];

  always @(negedge clk) begin : tgt
    logic s, d;
    s = scl;
    d = sda;
    if (tgt_clr) begin
      t_low = 1'b0; bitn = 0; sending = 0;
    end else if (ps && s && pd && !d) begin
      nstarts++; bitn = 0; sending = 0; first = 1; t_low = 1'b0;
    end else if (ps && s && !pd && d) begin
      nstops++; bitn = 0; sending = 0; t_low = 1'b0;
    end else if (!ps && s) begin
      if (!sending) begin
        if (bitn < 8) begin sr = {sr[6:0], d}; bitn++; end
      end else if (bitn < 8) bitn++;
      else if (bitn == 8) begin mack.push_back(!d); bitn = 9; end
    end else if (ps && !s) begin
      if (!sending) begin
        if (bitn == 8) begin
          t_low = (bq.size() != nak_at);
          bq.push_back(sr);
          bitn = 9;
        end else if (bitn == 9) begin
          t_low = 1'b0; bitn = 0;
          if (first && sr[0]) begin
            sending = 1;
            cur = (rdq.size() > 0) ? rdq.pop_front() : 8'hFF;
            t_low = !cur[7];
          end
          first = 0;
        end
      end else begin
        if (bitn > 0 && bitn < 8) t_low = !cur[3'(7 - bitn)];
        else if (bitn == 8) t_low = 1'b0;
        else if (bitn == 9) begin
          bitn = 0;
          if (mack[$]) begin
            cur = (rdq.size() > 0) ? rdq.pop_front() : 8'hFF;
            t_low = !cur[7];
          end else begin
            sending = 0; t_low = 1'b0;
          end
        end
      end
    end
    ps = s;
    pd = !sda_oe && !t_low;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_pend(input int b, input string req);
    logic [31:0] v;
    int n;
    v = '0; n = 0;
    while (!v[b] && n < 4000) begin rd(5'd5, v); n++; end
    check(req, 32'(v[b]), 32'd1);
  endtask

  task automatic do_start();
    wr(5'd5, 32'h1F);
    wr(5'd0, 32'h9);
    wait_pend(0, "R2 start done");
    wr(5'd5, 32'h1F);
  endtask

  task automatic do_stop();
    wr(5'd0, 32'h11);
    wait_pend(1, "R2 stop done");
    wr(5'd5, 32'h1F);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0] e[5];
    int b0, m0, s0;
    bit moved;
    logic so, dd;

    repeat (3) @(negedge clk);
    check("R1 scl_oe in reset", 32'(scl_oe), 0);
    check("R1 sda_oe in reset", 32'(sda_oe), 0);
    rst_n = 1'b1;
    rd(5'd5, v);
    check("R1 pending after reset", v, 0);

    // R2 / R3
    wr(5'd0, 32'h9);
    wait_pend(0, "R2 start flag");
    check("R2 scl held low after start", 32'(scl_oe), 1);
    check("R2 one start seen", nstarts, 1);
    wr(5'd5, 32'h2);
    rd(5'd5, v);
    check("R3 zero-bit write keeps flag", v, 32'h1);
    wr(5'd5, 32'h1);
    rd(5'd5, v);
    check("R3 write-one clears", v, 32'h0);

    // R4 transmit
    e = '{8'hA0, 8'h11, 8'h22, 8'h33, 8'h44};
    wr(5'd8, 32'h332211A0);
    wr(5'd9, 32'h00000044);
    wr(5'd0, 32'h1);
    b0 = bq.size();
    wr(5'd3, 32'd5);
    wait_pend(2, "R4 tx done flag");
    check("R4 byte count", bq.size() - b0, 5);
    for (int i = 0; i < 5; i++) check("R4 byte order", 32'(bq[b0 + i]), 32'(e[i]));
    rd(5'd5, v);
    check("R4 no nak", 32'(v[4]), 0);
    wr(5'd5, 32'h1F);

    do_stop();
    check("R2 lines released after stop", {30'd0, scl_oe, sda_oe}, 0);
    check("R2 one stop seen", nstops, 1);

    // R5/R6/R7 combined mode with 2 register bytes
    do_start();
    s0 = nstarts; b0 = bq.size(); m0 = mack.size();
    rdq = '{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5};
    wr(5'd1, 32'h3A);
    wr(5'd2, 32'h02001234);
    wr(5'd0, 32'h3);
    wr(5'd4, 32'd5);
    wait_pend(3, "R6 rx done flag");
    check("R5 header bytes", bq.size() - b0, 4);
    check("R5 write address", 32'(bq[b0]), 32'h74);
    check("R5 reg low byte", 32'(bq[b0 + 1]), 32'h34);
    check("R5 reg high byte", 32'(bq[b0 + 2]), 32'h12);
    check("R5 read address", 32'(bq[b0 + 3]), 32'h75);
    check("R5 repeated start", nstarts - s0, 1);
    rd(5'd16, v);
    check("R6 rx word0", v, 32'hC4C3C2C1);
    rd(5'd17, v);
    check("R6 rx word1 byte0", v & 32'hFF, 32'hC5);
    check("R7 ack count", mack.size() - m0, 5);
    for (int i = 0; i < 4; i++) check("R7 ack on middle byte", 32'(mack[m0 + i]), 1);
    check("R7 nak on last byte", 32'(mack[m0 + 4]), 0);
    wr(5'd5, 32'h1F);
    do_stop();

    // R5 zero-length register, R7 keep-ACK, R8 plain receive
    do_start();
    s0 = nstarts; b0 = bq.size(); m0 = mack.size();
    rdq = '{8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hD5, 8'hD6};
    wr(5'd2, 32'h0);
    wr(5'd0, 32'h23);
    wr(5'd4, 32'd3);
    wait_pend(3, "R6 first chunk done");
    check("R5 only read address", bq.size() - b0, 1);
    check("R5 read address value", 32'(bq[b0]), 32'h75);
    check("R5 no repeated start", nstarts - s0, 0);
    check("R7 keep-ACK last byte", 32'(mack[m0 + 2]), 1);
    wr(5'd5, 32'h1F);
    wr(5'd0, 32'h5);
    wr(5'd4, 32'd4);
    wait_pend(3, "R8 second chunk done");
    check("R8 no address byte", bq.size() - b0, 1);
    check("R8 no start", nstarts - s0, 0);
    rd(5'd16, v);
    check("R6 second chunk from byte 0", v, 32'hD6D5D4D3);
    check("R7 final nak", 32'(mack[mack.size() - 1]), 0);
    wr(5'd5, 32'h1F);
    do_stop();

    // R9 NAK
    do_start();
    b0 = bq.size();
    nak_at = b0 + 2;
    wr(5'd0, 32'h1);
    wr(5'd3, 32'd4);
    wait_pend(4, "R9 nak flag");
    check("R9 bytes before end", bq.size() - b0, 3);
    rd(5'd5, v);
    check("R9 no tx done", 32'(v[2]), 0);
    nak_at = -1;
    wr(5'd5, 32'h1F);
    do_stop();

    // R11 stall, R10 disable
    do_start();
    wr(5'd3, 32'd4);
    repeat (30) @(negedge clk);
    tick_en = 1'b0;
    repeat (2) @(negedge clk);
    so = scl_oe; dd = sda_oe; moved = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (scl_oe !== so || sda_oe !== dd) moved = 1;
    end
    check("R11 frozen without tick", 32'(moved), 0);
    wr(5'd0, 32'h0);
    check("R10 lines released after disable", {30'd0, scl_oe, sda_oe}, 0);
    tgt_clr = 1; @(negedge clk); tgt_clr = 0;
    tick_en = 1'b1;
    moved = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (scl_oe || sda_oe) moved = 1;
    end
    check("R10 no activity after disable", 32'(moved), 0);
    rd(5'd5, v);
    check("R10 no tx done after abort", 32'(v[2]), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule